// File: doc/BRIEF.md
# Bus Idle Detector and Slave Break Generator

This block sits beside a shared open-drain serial data line and looks for the quiet pattern during which an attached slave may ask the bus master for attention. It derives a slow sampling tick (nominally 0.5 ms, 2000 per second) from the system clock and samples the data line once per tick. A long enough low stretch followed by a long enough high stretch forms the idle pattern. When that pattern has been seen and a break is requested, the block pulls the line low for a fixed number of ticks and then lets go.

Packet logic elsewhere in the chip tells the block about every byte that crosses the bus through a one-cycle clear input. Bus traffic means the line is not idle, so the clear sends the detector back to its first phase. The block also reports the end of a completed break with a one-cycle pulse.

Top module: `idle_break_gen`

## Requirements
- R1: `tick` pulses high for exactly one clock cycle every DIV = CLK_HZ / TICK_HZ cycles. Its first pulse is on the DIV-th rising edge after reset is released.
- R2: While `rst` is high and in the cycle right after it, `tick`, `pull_low` and `brk_done` are all 0.
- R3: The first phase needs LOW_TICKS (default 10) consecutive tick samples with `line_in` = 0 (line low). A tick sample with `line_in` = 1 restarts this count.
- R4: The second phase needs HIGH_TICKS (default 4) consecutive tick samples with `line_in` = 1. `pull_low` becomes 1 in the cycle after the tick on which the last of these samples is taken, provided `brk_req` is 1 on that tick.
- R5: If `line_in` = 0 on the first tick of the second phase, only the second phase starts over.
- R6: If `line_in` = 0 on any later tick of the second phase, the whole sequence returns to the first phase.
- R7: A break keeps `pull_low` = 1 for exactly BREAK_TICKS (default 10) tick periods. On release, `brk_done` is 1 for a single cycle, in the same cycle that `pull_low` returns to 0.
- R8: No break starts while `brk_req` = 0. While it waits, the detector stays armed: its high count saturates. The break then starts on the first tick that has `brk_req` = 1 and `line_in` = 1. If `brk_req` drops during a break, `pull_low` falls in the next cycle and no `brk_done` pulse is produced.
- R9: A cycle with `byte_rx` = 1 returns the block to the first phase with cleared counts in the next cycle. This ends any break at once, with no `brk_done` pulse.
- R10: During a break, the value of `line_in` has no effect on how long the break lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Sampled data line level, 1 = released/high, 0 = low |
| brk_req | input | 1 | A break is wanted; must stay high through the break |
| byte_rx | input | 1 | One-cycle strobe for each byte seen on the bus |
| tick | output | 1 | One-cycle sampling tick from the prescaler |
| pull_low | output | 1 | 1 = drive the open-drain data line low |
| brk_done | output | 1 | One-cycle pulse when a full break is released |

## Verification
Every effect of a tick sample lands one clock cycle after the cycle in which `tick` is high, because the phase state is a single register stage fed by the registered tick. A `byte_rx` strobe or a drop of `brk_req` shows up on `pull_low` in the very next cycle. `brk_done` appears in the same cycle that `pull_low` falls. The bench advances a reference model once per clock, using the inputs that the next rising edge will see. It compares all three outputs at every falling edge, so each result is checked in exactly the cycle in which it is due. The directed cases are built around tick counting, so they line up the phase boundaries with the limits of R3 to R8.

// File: rtl/ibg_pkg.sv
package ibg_pkg;

    typedef enum logic [1:0] {
        PH_LOW   = 2'd0,
        PH_HIGH  = 2'd1,
        PH_BREAK = 2'd2
    } phase_e;

    function automatic int unsigned clk_per_tick(input int unsigned clk_hz,
                                                 input int unsigned tick_hz);
        int unsigned d;
        d = clk_hz / tick_hz;
        return (d < 1) ? 1 : d;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned bits_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ibg_tick_gen.sv
module ibg_tick_gen #(
    parameter int unsigned DIV = 25000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV < 2) begin : g_every
            always_ff @(posedge clk) begin
                if (rst) tick <= 1'b0;
                else     tick <= 1'b1;
            end
        end else begin : g_div
            localparam int unsigned W = $clog2(DIV);
            localparam logic [W-1:0] LAST = W'(DIV - 1);
            logic [W-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt  <= '0;
                    tick <= 1'b0;
                end else begin
                    tick <= (cnt == LAST);
                    cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
                end
            end

            assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/ibg_phase_ctrl.sv
module ibg_phase_ctrl
    import ibg_pkg::*;
#(
    parameter int unsigned LOW_TICKS   = 10,
    parameter int unsigned HIGH_TICKS  = 4,
    parameter int unsigned BREAK_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line_in,
    input  logic brk_req,
    input  logic byte_rx,
    output logic pull_low,
    output logic brk_done
);
    localparam int unsigned MAXT = max3(LOW_TICKS, HIGH_TICKS, BREAK_TICKS);
    localparam int unsigned CW   = bits_for(MAXT);
    localparam logic [CW-1:0] L_LIM = CW'(LOW_TICKS);
    localparam logic [CW-1:0] H_LIM = CW'(HIGH_TICKS);
    localparam logic [CW-1:0] B_LIM = CW'(BREAK_TICKS);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          done;
    } ctl_t;

    ctl_t          cur, nxt;
    logic [CW-1:0] inc;

    always_comb begin
        inc = (cur.cnt == '1) ? cur.cnt : cur.cnt + 1'b1;
        nxt = cur;
        nxt.done = 1'b0;
        if (byte_rx) begin
            nxt.ph  = PH_LOW;
            nxt.cnt = '0;
        end else if (cur.ph == PH_BREAK && !brk_req) begin
            nxt.ph  = PH_LOW;
            nxt.cnt = '0;
        end else if (tick) begin
            unique case (cur.ph)
                PH_LOW: begin
                    if (line_in) begin
                        nxt.cnt = '0;
                    end else if (inc >= L_LIM) begin
                        nxt.ph  = PH_HIGH;
                        nxt.cnt = '0;
                    end else begin
                        nxt.cnt = inc;
                    end
                end
                PH_HIGH: begin
                    if (!line_in) begin
                        if (cur.cnt != '0) nxt.ph = PH_LOW;
                        nxt.cnt = '0;
                    end else if (inc >= H_LIM && brk_req) begin
                        nxt.ph  = PH_BREAK;
                        nxt.cnt = '0;
                    end else begin
                        nxt.cnt = (inc >= H_LIM) ? H_LIM : inc;
                    end
                end
                PH_BREAK: begin
                    if (inc >= B_LIM) begin
                        nxt.ph   = PH_LOW;
                        nxt.cnt  = '0;
                        nxt.done = 1'b1;
                    end else begin
                        nxt.cnt = inc;
                    end
                end
                default: begin
                    nxt.ph  = PH_LOW;
                    nxt.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.ph   <= PH_LOW;
            cur.cnt  <= '0;
            cur.done <= 1'b0;
        end else begin
            cur <= nxt;
        end
    end

    assign pull_low = (cur.ph == PH_BREAK);
    assign brk_done = cur.done;

    assert_low_phase_R3: assert property (@(posedge clk) disable iff (rst)
        (cur.ph == PH_HIGH && $past(cur.ph) == PH_LOW) |-> $past(tick && !line_in));

    assert_break_entry_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pull_low) |-> $past(tick && line_in && brk_req));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        brk_done |=> !brk_done);

    assert_done_release_R7: assert property (@(posedge clk) disable iff (rst)
        brk_done |-> ($past(pull_low) && !pull_low));

    assert_req_gate_R8: assert property (@(posedge clk) disable iff (rst)
        !brk_req |=> !pull_low);

    assert_byte_clear_R9: assert property (@(posedge clk) disable iff (rst)
        byte_rx |=> (!pull_low && !brk_done));
endmodule

// File: rtl/idle_break_gen.sv
module idle_break_gen
    import ibg_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned TICK_HZ     = 2000,
    parameter int unsigned LOW_TICKS   = 10,
    parameter int unsigned HIGH_TICKS  = 4,
    parameter int unsigned BREAK_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic brk_req,
    input  logic byte_rx,
    output logic tick,
    output logic pull_low,
    output logic brk_done
);
    localparam int unsigned DIV = clk_per_tick(CLK_HZ, TICK_HZ);

    ibg_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    ibg_phase_ctrl #(
        .LOW_TICKS   (LOW_TICKS),
        .HIGH_TICKS  (HIGH_TICKS),
        .BREAK_TICKS (BREAK_TICKS)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .line_in  (line_in),
        .brk_req  (brk_req),
        .byte_rx  (byte_rx),
        .pull_low (pull_low),
        .brk_done (brk_done)
    );
endmodule

// File: tb/sim_idle_break_gen.sv
module sim_idle_break_gen;
    localparam int CLK_HZ = 16000;
    localparam int TICK_HZ = 2000;
    localparam int DIV = CLK_HZ / TICK_HZ;
    localparam int LT = 10;
    localparam int HT = 4;
    localparam int BT = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_in = 1'b1;
    logic brk_req = 1'b0;
    logic byte_rx = 1'b0;
    logic tick, pull_low, brk_done;

    int checks = 0;
    int errors = 0;
    string tag = "R2";
    bit finished = 1'b0;

    int m_pcnt, m_ph, m_cnt;
    bit m_tick, m_done, consumed;

    always #2 clk = ~clk;

    idle_break_gen #(
        .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ),
        .LOW_TICKS(LT), .HIGH_TICKS(HT), .BREAK_TICKS(BT)
    ) u0 (
        .clk(clk), .rst(rst), .line_in(line_in), .brk_req(brk_req),
        .byte_rx(byte_rx), .tick(tick), .pull_low(pull_low), .brk_done(brk_done)
    );

    function automatic void check(string t, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
        end
    endfunction

    // Reference from the requirements, advanced with the inputs the next edge sees.
    task automatic model_step();
        bit t;
        if (rst) begin
            m_pcnt = 0; m_tick = 0; m_ph = 0; m_cnt = 0; m_done = 0; consumed = 0;
            return;
        end
        t = m_tick;
        consumed = t;
        m_tick = (m_pcnt == DIV - 1);
        m_pcnt = (m_pcnt == DIV - 1) ? 0 : m_pcnt + 1;
        m_done = 0;
        if (byte_rx) begin
            m_ph = 0; m_cnt = 0;
        end else if (m_ph == 2 && !brk_req) begin
            m_ph = 0; m_cnt = 0;
        end else if (t) begin
            case (m_ph)
                0: if (line_in) m_cnt = 0;
                   else if (m_cnt + 1 >= LT) begin m_ph = 1; m_cnt = 0; end
                   else m_cnt++;
                1: if (!line_in) begin
                       if (m_cnt != 0) m_ph = 0;
                       m_cnt = 0;
                   end else if (m_cnt + 1 >= HT && brk_req) begin m_ph = 2; m_cnt = 0; end
                   else m_cnt = (m_cnt + 1 >= HT) ? HT : m_cnt + 1;
                default: if (m_cnt + 1 >= BT) begin m_ph = 0; m_cnt = 0; m_done = 1; end
                   else m_cnt++;
            endcase
        end
    endtask

    task automatic cyc();
        model_step();
        @(negedge clk);
        check("R1", "tick", int'(tick), int'(m_tick));
        check(tag, "pull_low", int'(pull_low), int'(m_ph == 2));
        check(tag, "brk_done", int'(brk_done), int'(m_done));
    endtask

    task automatic ticks(int n);
        int seen = 0;
        while (seen < n) begin
            cyc();
            if (consumed) seen++;
        end
    endtask

    initial begin
        int unsigned s;
        s = $urandom(32'd4242);
        repeat (3) cyc();
        check("R2", "reset pull_low", int'(pull_low), 0);
        check("R2", "reset brk_done", int'(brk_done), 0);
        check("R2", "reset tick", int'(tick), 0);
        rst = 1'b0;
        cyc();
        check("R2", "post-reset pull_low", int'(pull_low), 0);

        // R3: low run cut short by a high sample, then a full low run
        tag = "R3"; brk_req = 1'b1; line_in = 1'b0;
        ticks(LT - 1);
        line_in = 1'b1; ticks(1);
        line_in = 1'b0; ticks(LT);
        // R4: high run reaches its limit with a request pending
        tag = "R4"; line_in = 1'b1;
        ticks(HT - 1);
        check("R4", "no break before high limit", int'(pull_low), 0);
        ticks(1);
        check("R4", "break starts", int'(pull_low), 1);
        // R10/R7: line level is ignored while the break runs
        tag = "R10"; line_in = 1'b1;
        ticks(BT - 1);
        check("R10", "break still held", int'(pull_low), 1);
        tag = "R7"; ticks(1);
        check("R7", "break released", int'(pull_low), 0);
        check("R7", "done pulse", int'(brk_done), 1);
        cyc();
        check("R7", "done single cycle", int'(brk_done), 0);

        // R5: low on the first high-phase tick restarts only that phase
        tag = "R5"; line_in = 1'b0; ticks(LT);
        ticks(1);
        line_in = 1'b1; ticks(HT);
        check("R5", "break after restarted high phase", int'(pull_low), 1);
        tag = "R8"; brk_req = 1'b0; cyc();
        check("R8", "request drop releases", int'(pull_low), 0);
        check("R8", "no done on abort", int'(brk_done), 0);

        // R6: low later in the high phase restarts everything
        tag = "R6"; brk_req = 1'b1; line_in = 1'b0; ticks(LT);
        line_in = 1'b1; ticks(2);
        line_in = 1'b0; ticks(1);
        line_in = 1'b1; ticks(HT);
        check("R6", "no break after full restart", int'(pull_low), 0);
        line_in = 1'b0; ticks(LT);
        line_in = 1'b1; ticks(HT);
        check("R6", "break after fresh sequence", int'(pull_low), 1);
        brk_req = 1'b0; cyc();

        // R8: armed wait without a request
        tag = "R8"; line_in = 1'b0; ticks(LT);
        line_in = 1'b1; ticks(HT + 5);
        check("R8", "no break without request", int'(pull_low), 0);
        brk_req = 1'b1; ticks(1);
        check("R8", "break on first requested tick", int'(pull_low), 1);
        ticks(BT);
        check("R8", "full break then done", int'(brk_done), 1);

        // R9: byte clears mid-detection and mid-break
        tag = "R9"; line_in = 1'b0; ticks(LT);
        line_in = 1'b1; ticks(2);
        byte_rx = 1'b1; cyc(); byte_rx = 1'b0;
        ticks(HT + 2);
        check("R9", "no break after byte clear", int'(pull_low), 0);
        line_in = 1'b0; ticks(LT);
        line_in = 1'b1; ticks(HT);
        check("R9", "break running", int'(pull_low), 1);
        byte_rx = 1'b1; cyc(); byte_rx = 1'b0;
        check("R9", "byte ends break", int'(pull_low), 0);
        check("R9", "no done after byte", int'(brk_done), 0);

        // Random runs of line levels, requests and bytes
        tag = "R4";
        for (int seg = 0; seg < 120; seg++) begin
            int len;
            len = $urandom_range(1, 14);
            line_in = ~line_in;
            brk_req = ($urandom_range(0, 9) < 8);
            for (int k = 0; k < len * DIV; k++) begin
                byte_rx = ($urandom_range(0, 599) == 0);
                cyc();
            end
            byte_rx = 1'b0;
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule